// File: doc/BRIEF.md
# Shadow Stack Token Busy-Clear Unit

This unit runs one privileged instruction that releases a supervisor shadow stack token. A start pulse presents the operand linear address and the current machine context. These are the privilege level, the operating mode, whether a lock prefix was seen, the global control-flow enforcement enable, the supervisor shadow-stack enable, and whether the operand is addressed through the stack segment. The unit first checks these against a fixed priority of fault conditions. If none applies, it issues one locked 64-bit compare-and-exchange to memory. The expected old value is the token address with its busy bit (bit 0) set. The replacement value is the same address with bit 0 clear.

The memory request is a valid/ready channel. Once `mem_req_valid` rises, the address, compare value and new value stay stable until `mem_req_ready` is sampled high, and memory may stall for any number of cycles. The response channel has no ready signal. The unit accepts a response on any cycle after the request handshake, and memory must send exactly one response per accepted request.

If the word read back does not match the expected value, the token is invalid. The unit reports this in the carry flag and does not fault. In both cases it writes zero to the shadow stack pointer. Address translation and segment-limit checks happen upstream.

Top module: `ssb_unit`

## Requirements
- R1: Exception codes on `exc` are 0 none, 1 undefined-opcode, 2 general-protection, 3 stack-fault, 4 page-fault. When the global enable `cet_en` is 0, the result is undefined-opcode, ahead of every other check.
- R2: When `sss_en` is 0, the result is undefined-opcode, ahead of any privilege, alignment or canonical check.
- R3: A set `op_lock`, or `op_mode` equal to 0 (real-address) or 1 (virtual-8086), gives undefined-opcode. Mode 2 is protected/compatibility and mode 3 is 64-bit.
- R4: With no undefined-opcode cause, an `op_cpl` other than 0 gives general-protection.
- R5: At privilege 0, an address whose bits [2:0] are not all zero gives general-protection.
- R6: In mode 3 only, an address whose bits [63:47] are not all equal gives stack-fault when `op_seg_ss` is 1 and general-protection otherwise. Other modes skip this check.
- R7: A fault-free start issues exactly one request, with `mem_req_addr` equal to the operand, `mem_req_cmp` equal to the address with bit 0 set, and `mem_req_new` equal to the address with bit 0 clear. These are held stable while `mem_req_valid` is high and `mem_req_ready` is low.
- R8: On a response without page fault, `flag_cf` becomes 1 exactly when `mem_rsp_data` differs from the compare value. `flag_zf`, `flag_pf`, `flag_af`, `flag_of` and `flag_sf` become 0.
- R9: On a response without page fault, `ssp_out` becomes 0 whether or not the token was valid. After reset it holds parameter `SSP_INIT`.
- R10: A detected fault issues no request, keeps `arch_we` low, and leaves the flags and `ssp_out` unchanged.
- R11: A response with `mem_rsp_pf` set ends the instruction with page-fault, `arch_we` low, and the flags and `ssp_out` unchanged.
- R12: `done` pulses for one cycle, either one cycle after a start that faults or one cycle after the response. `arch_we` is high only with a fault-free `done`. A start while an instruction is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one instruction (ignored while busy) |
| op_addr | input | 64 | Operand linear address |
| op_cpl | input | 2 | Current privilege level |
| op_mode | input | 2 | 0 real, 1 virtual-8086, 2 protected/compat, 3 64-bit |
| op_lock | input | 1 | Lock prefix present |
| op_seg_ss | input | 1 | Operand addressed through the stack segment |
| cet_en | input | 1 | Global control-flow enforcement enable |
| sss_en | input | 1 | Supervisor shadow-stack enable |
| mem_req_valid | output | 1 | Locked compare-exchange request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Token address |
| mem_req_cmp | output | 64 | Expected old token value |
| mem_req_new | output | 64 | Replacement token value |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_data | input | 64 | Old value read from memory |
| mem_rsp_pf | input | 1 | Response reports a page fault |
| done | output | 1 | Instruction finished (one-cycle pulse) |
| exc | output | 3 | Exception code, valid with `done` |
| arch_we | output | 1 | Flags and SSP were updated (with `done`) |
| flag_cf | output | 1 | Carry flag (invalid token) |
| flag_zf | output | 1 | Zero flag |
| flag_pf | output | 1 | Parity flag |
| flag_af | output | 1 | Auxiliary-carry flag |
| flag_of | output | 1 | Overflow flag |
| flag_sf | output | 1 | Sign flag |
| ssp_out | output | 64 | Shadow stack pointer |

## Verification
The assertions check several rules on every cycle:
- a stalled request stays stable;
- the busy-bit encoding of the compare and new values is correct;
- only aligned addresses reach memory;
- any change of carry or SSP happens only with a fault-free completion, which always zeroes SSP and the other flags;
- a page-fault code follows only a page-fault response.

Other behaviour can only be shown by the bench's scenarios:
- the relative priority of the undefined-opcode, general-protection and stack-fault causes;
- the canonical check being limited to 64-bit mode;
- the carry value against matching and mismatching tokens;
- starts being ignored while a request is outstanding.

// File: rtl/ssb_pkg.sv
package ssb_pkg;

  typedef enum logic [2:0] {
    EXC_NONE = 3'd0,
    EXC_UD   = 3'd1,
    EXC_GP   = 3'd2,
    EXC_SS   = 3'd3,
    EXC_PF   = 3'd4
  } exc_e;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_V86  = 2'd1,
    MODE_PROT = 2'd2,
    MODE_LONG = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } state_e;

endpackage

// File: rtl/ssb_fault_chk.sv
module ssb_fault_chk
  import ssb_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int VA_BITS    = 48,
  parameter int ALIGN_BITS = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        cpl,
  input  logic [1:0]        mode,
  input  logic              lock_pfx,
  input  logic              seg_ss,
  input  logic              cet_en,
  input  logic              sss_en,
  output exc_e              code
);

  logic canon;

  // Canonical form: every bit from VA_BITS-1 upward equals the sign bit.
  generate
    if (VA_BITS >= ADDR_W) begin : g_full
      assign canon = 1'b1;
    end else begin : g_sext
      localparam int HI_W = ADDR_W - VA_BITS + 1;
      logic [HI_W-1:0] hi;
      assign hi    = addr[ADDR_W-1:VA_BITS-1];
      assign canon = (&hi) | ~(|hi);
    end
  endgenerate

  logic bad_mode;
  assign bad_mode = (mode == MODE_REAL) || (mode == MODE_V86);

  // Fixed priority: undefined-opcode causes, then privilege, alignment, canonical.
  always_comb begin
    code = EXC_NONE;
    if (!cet_en)                         code = EXC_UD;
    else if (lock_pfx || bad_mode)       code = EXC_UD;
    else if (!sss_en)                    code = EXC_UD;
    else if (cpl != 2'd0)                code = EXC_GP;
    else if (|addr[ALIGN_BITS-1:0])      code = EXC_GP;
    else if (mode == MODE_LONG && !canon) code = seg_ss ? EXC_SS : EXC_GP;
  end

endmodule

// File: rtl/ssb_token_calc.sv
module ssb_token_calc #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [ADDR_W-1:0] old_val,
  output logic [ADDR_W-1:0] cmp_val,
  output logic [ADDR_W-1:0] new_val,
  output logic              mismatch
);

  // Bit 0 of a token is its busy marker; the remaining bits hold the address.
  assign cmp_val  = {tok_addr[ADDR_W-1:1], 1'b1};
  assign new_val  = {tok_addr[ADDR_W-1:1], 1'b0};
  assign mismatch = (old_val != cmp_val);

endmodule

// File: rtl/ssb_seq.sv
module ssb_seq
  import ssb_pkg::*;
#(
  parameter int              ADDR_W   = 64,
  parameter logic [63:0]     SSP_INIT = 64'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] op_addr,
  input  exc_e              fault,
  output logic [ADDR_W-1:0] addr_q,
  output logic              req_valid,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic              rsp_pf,
  input  logic              tok_bad,
  output logic              done,
  output exc_e              exc_q,
  output logic              arch_we,
  output logic [5:0]        flags_q,   // {sf, of, af, pf, zf, cf}
  output logic [ADDR_W-1:0] ssp_q
);

  state_e st;

  assign req_valid = (st == ST_REQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      addr_q  <= '0;
      done    <= 1'b0;
      exc_q   <= EXC_NONE;
      arch_we <= 1'b0;
      flags_q <= '0;
      ssp_q   <= SSP_INIT[ADDR_W-1:0];
    end else begin
      done    <= 1'b0;
      exc_q   <= EXC_NONE;
      arch_we <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            if (fault != EXC_NONE) begin
              done  <= 1'b1;
              exc_q <= fault;
            end else begin
              addr_q <= op_addr;
              st     <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (req_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            done <= 1'b1;
            st   <= ST_IDLE;
            if (rsp_pf) begin
              exc_q <= EXC_PF;
            end else begin
              arch_we <= 1'b1;
              flags_q <= {5'b0, tok_bad};
              ssp_q   <= '0;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ssb_unit.sv
module ssb_unit
  import ssb_pkg::*;
#(
  parameter int          ADDR_W     = 64,
  parameter int          VA_BITS    = 48,
  parameter int          ALIGN_BITS = 3,
  parameter logic [63:0] SSP_INIT   = 64'h0000_7FFF_FFFF_F000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [1:0]        op_cpl,
  input  logic [1:0]        op_mode,
  input  logic              op_lock,
  input  logic              op_seg_ss,
  input  logic              cet_en,
  input  logic              sss_en,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [ADDR_W-1:0] mem_req_cmp,
  output logic [ADDR_W-1:0] mem_req_new,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_pf,
  output logic              done,
  output logic [2:0]        exc,
  output logic              arch_we,
  output logic              flag_cf,
  output logic              flag_zf,
  output logic              flag_pf,
  output logic              flag_af,
  output logic              flag_of,
  output logic              flag_sf,
  output logic [ADDR_W-1:0] ssp_out
);

  exc_e              fault;
  exc_e              exc_q;
  logic [ADDR_W-1:0] addr_q;
  logic              tok_bad;
  logic [5:0]        flags_q;

  ssb_fault_chk #(
    .ADDR_W    (ADDR_W),
    .VA_BITS   (VA_BITS),
    .ALIGN_BITS(ALIGN_BITS)
  ) u_fault (
    .addr    (op_addr),
    .cpl     (op_cpl),
    .mode    (op_mode),
    .lock_pfx(op_lock),
    .seg_ss  (op_seg_ss),
    .cet_en  (cet_en),
    .sss_en  (sss_en),
    .code    (fault)
  );

  ssb_token_calc #(
    .ADDR_W(ADDR_W)
  ) u_tok (
    .tok_addr(addr_q),
    .old_val (mem_rsp_data),
    .cmp_val (mem_req_cmp),
    .new_val (mem_req_new),
    .mismatch(tok_bad)
  );

  ssb_seq #(
    .ADDR_W  (ADDR_W),
    .SSP_INIT(SSP_INIT)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_addr  (op_addr),
    .fault    (fault),
    .addr_q   (addr_q),
    .req_valid(mem_req_valid),
    .req_ready(mem_req_ready),
    .rsp_valid(mem_rsp_valid),
    .rsp_pf   (mem_rsp_pf),
    .tok_bad  (tok_bad),
    .done     (done),
    .exc_q    (exc_q),
    .arch_we  (arch_we),
    .flags_q  (flags_q),
    .ssp_q    (ssp_out)
  );

  assign mem_req_addr = addr_q;
  assign exc          = exc_q;
  assign flag_cf      = flags_q[0];
  assign flag_zf      = flags_q[1];
  assign flag_pf      = flags_q[2];
  assign flag_af      = flags_q[3];
  assign flag_of      = flags_q[4];
  assign flag_sf      = flags_q[5];

endmodule

// File: rtl/ssb_sva.sv
module ssb_sva #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [ADDR_W-1:0] mem_req_cmp,
  input logic [ADDR_W-1:0] mem_req_new,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_pf,
  input logic              done,
  input logic [2:0]        exc,
  input logic              arch_we,
  input logic              flag_cf,
  input logic              flag_zf,
  input logic              flag_pf,
  input logic              flag_af,
  input logic              flag_of,
  input logic              flag_sf,
  input logic [ADDR_W-1:0] ssp_out
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_cmp)); // R7

  AST_BUSY_BIT_CODING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_cmp[0] && !mem_req_new[0] && mem_req_cmp[ADDR_W-1:1] == mem_req_addr[ADDR_W-1:1]); // R7

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'd0); // R5

  AST_WE_CLEAN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    arch_we |-> done && exc == 3'd0); // R12

  AST_SSP_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    arch_we |-> ssp_out == '0); // R9

  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    arch_we |-> !(flag_zf || flag_pf || flag_af || flag_of || flag_sf)); // R8

  AST_STATE_ONLY_ON_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({flag_cf, ssp_out}) |-> arch_we); // R10

  AST_PF_FROM_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    done && exc == 3'd4 |-> $past(mem_rsp_valid && mem_rsp_pf)); // R11

  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |=> done); // R12

  AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req_valid); // R10

endmodule

bind ssb_unit ssb_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .mem_req_cmp  (mem_req_cmp),
  .mem_req_new  (mem_req_new),
  .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_pf   (mem_rsp_pf),
  .done         (done),
  .exc          (exc),
  .arch_we      (arch_we),
  .flag_cf      (flag_cf),
  .flag_zf      (flag_zf),
  .flag_pf      (flag_pf),
  .flag_af      (flag_af),
  .flag_of      (flag_of),
  .flag_sf      (flag_sf),
  .ssp_out      (ssp_out)
);

// File: tb/sim_ssb_unit.sv
`timescale 1ns/1ps
module sim_ssb_unit;

  localparam logic [63:0] SSP_INIT = 64'h0000_7FFF_FFFF_F000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] op_addr = '0;
  logic [1:0]  op_cpl = '0;
  logic [1:0]  op_mode = 2'd3;
  logic        op_lock = 1'b0;
  logic        op_seg_ss = 1'b0;
  logic        cet_en = 1'b1;
  logic        sss_en = 1'b1;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr, mem_req_cmp, mem_req_new;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_rsp_pf = 1'b0;
  logic        done;
  logic [2:0]  exc;
  logic        arch_we;
  logic        flag_cf, flag_zf, flag_pf, flag_af, flag_of, flag_sf;
  logic [63:0] ssp_out;

  int n_chk = 0;
  int n_err = 0;
  logic        m_cf  = 1'b0;
  logic [63:0] m_ssp = SSP_INIT;

  always #2.5 clk = ~clk;

  ssb_unit #(.SSP_INIT(SSP_INIT)) u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] f_exc(input logic lock, input logic [1:0] mode,
      input logic cet, input logic sss, input logic [1:0] cpl,
      input logic [63:0] a, input logic ss);
    logic canon;
    canon = (a[63:47] == '0) || (a[63:47] == '1);
    if (!cet) return 3'd1;
    if (lock || mode == 2'd0 || mode == 2'd1) return 3'd1;
    if (!sss) return 3'd1;
    if (cpl != 0) return 3'd2;
    if (a[2:0] != 0) return 3'd2;
    if (mode == 2'd3 && !canon) return ss ? 3'd3 : 3'd2;
    return 3'd0;
  endfunction

  task automatic do_op(input logic lock, input logic [1:0] mode, input logic cet,
      input logic sss, input logic [1:0] cpl, input logic [63:0] a, input logic ss,
      input bit tok_ok, input logic [63:0] junk, input bit pf,
      input int rdy_dly, input int rsp_dly, input string tag);
    logic [2:0]  e;
    logic [63:0] rd;
    e = f_exc(lock, mode, cet, sss, cpl, a, ss);
    @(negedge clk);
    op_lock = lock; op_mode = mode; cet_en = cet; sss_en = sss;
    op_cpl = cpl; op_addr = a; op_seg_ss = ss; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op_addr = ~a;
    if (e != 3'd0) begin
      chk(done === 1'b1, tag, "done after fault", {63'b0, done}, 64'd1);
      chk(exc === e, tag, "fault code", {61'b0, exc}, {61'b0, e});
      chk(mem_req_valid === 1'b0, "R10", "no request on fault", {63'b0, mem_req_valid}, 64'd0);
      chk(arch_we === 1'b0 && flag_cf === m_cf && ssp_out === m_ssp, "R10",
          "state unchanged on fault", ssp_out, m_ssp);
    end else begin
      chk(mem_req_valid === 1'b1 && done === 1'b0, "R7", "request raised", {63'b0, mem_req_valid}, 64'd1);
      chk(mem_req_addr === a, "R7", "request address", mem_req_addr, a);
      chk(mem_req_cmp === (a | 64'd1) && mem_req_new === a, "R7", "compare value",
          mem_req_cmp, a | 64'd1);
      for (int i = 0; i < rdy_dly; i++) begin
        start = (i == 0); op_lock = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(mem_req_valid === 1'b1 && mem_req_addr === a && done === 1'b0, "R12",
            "held while stalled, start ignored", mem_req_addr, a);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk(mem_req_valid === 1'b0, "R7", "single request", {63'b0, mem_req_valid}, 64'd0);
      for (int i = 0; i < rsp_dly; i++) begin
        @(negedge clk);
        chk(done === 1'b0, "R12", "no done before response", {63'b0, done}, 64'd0);
      end
      rd = tok_ok ? (a | 64'd1) : junk;
      mem_rsp_valid = 1'b1; mem_rsp_data = rd; mem_rsp_pf = pf;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_pf = 1'b0;
      chk(done === 1'b1, "R12", "done after response", {63'b0, done}, 64'd1);
      if (pf) begin
        chk(exc === 3'd4 && arch_we === 1'b0, "R11", "page fault code", {61'b0, exc}, 64'd4);
        chk(flag_cf === m_cf && ssp_out === m_ssp, "R11", "state kept on page fault", ssp_out, m_ssp);
      end else begin
        chk(exc === 3'd0 && arch_we === 1'b1, "R12", "clean completion", {61'b0, exc}, 64'd0);
        chk(flag_cf === !tok_ok, "R8", "carry flag", {63'b0, flag_cf}, {63'b0, !tok_ok});
        chk({flag_zf, flag_pf, flag_af, flag_of, flag_sf} === 5'b0, "R8", "other flags",
            {59'b0, flag_zf, flag_pf, flag_af, flag_of, flag_sf}, 64'd0);
        chk(ssp_out === 64'd0, "R9", "ssp cleared", ssp_out, 64'd0);
        m_cf = !tok_ok; m_ssp = 64'd0;
      end
    end
    @(negedge clk);
    chk(done === 1'b0, "R12", "done is a pulse", {63'b0, done}, 64'd0);
  endtask

  function automatic logic [63:0] canon_addr(input logic [63:0] r);
    return {{16{r[47]}}, r[47:3], 3'b000};
  endfunction

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [63:0] a0;
    a0 = 64'hFFFF_8000_1234_5670;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done === 0 && mem_req_valid === 0 && arch_we === 0 && flag_cf === 0, "R12",
        "reset outputs idle", {62'b0, done, mem_req_valid}, 64'd0);
    chk(ssp_out === SSP_INIT, "R9", "reset ssp", ssp_out, SSP_INIT);

    // R1: global disable wins over privilege and alignment
    do_op(0, 3, 0, 1, 3, a0 | 64'd5, 0, 1, 0, 0, 0, 0, "R1");
    // R2: supervisor disable wins over privilege
    do_op(0, 3, 1, 0, 3, a0, 0, 1, 0, 0, 0, 0, "R2");
    // R3: lock prefix, real mode, virtual-8086 mode
    do_op(1, 3, 1, 1, 0, a0, 0, 1, 0, 0, 0, 0, "R3");
    do_op(0, 0, 1, 1, 0, a0, 0, 1, 0, 0, 0, 0, "R3");
    do_op(0, 1, 1, 1, 3, a0, 0, 1, 0, 0, 0, 0, "R3");
    // R4: nonzero privilege
    do_op(0, 3, 1, 1, 1, a0, 0, 1, 0, 0, 0, 0, "R4");
    // R5: misalignment
    do_op(0, 3, 1, 1, 0, a0 | 64'd4, 0, 1, 0, 0, 0, 0, "R5");
    do_op(0, 2, 1, 1, 0, a0 | 64'd1, 0, 1, 0, 0, 0, 0, "R5");
    // R8/R9: valid token then invalid token
    do_op(0, 3, 1, 1, 0, a0, 0, 1, 0, 0, 2, 1, "R8");
    do_op(0, 3, 1, 1, 0, a0, 0, 0, a0, 0, 0, 0, "R8");
    // R6: non-canonical in 64-bit mode, general-protection vs stack-fault
    do_op(0, 3, 1, 1, 0, 64'h0001_0000_0000_0008, 0, 1, 0, 0, 0, 0, "R6");
    do_op(0, 3, 1, 1, 0, 64'h0001_0000_0000_0008, 1, 1, 0, 0, 0, 0, "R6");
    // R6: no canonical check outside 64-bit mode
    do_op(0, 2, 1, 1, 0, 64'h0001_0000_0000_0008, 1, 1, 0, 0, 1, 0, "R6");
    // R11: page fault response
    do_op(0, 3, 1, 1, 0, a0, 0, 1, 0, 1, 1, 1, "R11");
    // R10: fault after an invalid-token completion keeps carry set
    do_op(0, 3, 1, 1, 0, a0, 0, 0, 64'd7, 0, 0, 0, "R8");
    do_op(0, 3, 1, 1, 2, a0, 0, 1, 0, 0, 0, 0, "R10");

    void'($urandom(32'd20240611));
    for (int k = 0; k < 400; k++) begin
      logic [63:0] r, a, j;
      logic [1:0]  md, cp;
      r  = {$urandom, $urandom};
      a  = ($urandom % 6 != 0) ? canon_addr(r) : r;
      if ($urandom % 6 == 0) a[2:0] = 3'($urandom % 8);
      md = ($urandom % 8 < 6) ? 2'd3 : 2'($urandom % 4);
      cp = ($urandom % 5 == 0) ? 2'($urandom % 4) : 2'd0;
      j  = {$urandom, $urandom};
      if (j == (a | 64'd1)) j = a;
      do_op(($urandom % 8) == 0, md, ($urandom % 10) != 0, ($urandom % 10) != 0, cp, a,
            1'($urandom % 2), 1'($urandom % 2), j, ($urandom % 6) == 0,
            int'($urandom % 4), int'($urandom % 4), "R12");
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule